// File: doc/BRIEF.md
# Reorder Buffer with Youngest-Writer Operand Lookup

This block is the in-order retirement queue of a small out-of-order integer core. When the front end issues an instruction, the block claims the slot at the tail and hands back that slot number as a tag. Functional units later report their results against the tag. The block retires the oldest slot once its result is present. Each retirement is presented on a one-cycle commit bundle. The bundle carries the register write, the slot tag and the resulting PC. When the unit that produced the result flagged a wrong next-PC, the bundle also raises a redirect, and the whole queue is emptied on the following clock edge.

Alongside this, the block answers source-operand queries on a configurable number of lookup ports. Each port supplies an architectural register number. The block scans the occupied slots from oldest to youngest. A completed slot that writes that register supplies its value. A slot that writes the register but has not yet completed cancels any older hit. The answer is therefore a hit only when the youngest in-flight writer already has its value. Register zero never hits.

Top module: `reorder_buf`

## Requirements
- R1: After reset the queue is empty: `iss_ready` is 1, `iss_tag` is 0, `cm_valid` and `cm_redirect` are 0, and every `q_hit` bit is 0.
- R2: Slots are handed out in sequence. `iss_tag` shows the tail slot. Each accepted issue (`iss_valid` and `iss_ready` both 1 at a clock edge) advances it by one, wrapping from DEPTH-1 to 0.
- R3: `iss_ready` is 1 exactly when (DEPTH minus occupancy) is greater than 1 if an issue was accepted at the previous edge, and greater than 0 otherwise. Back-to-back issue into an empty queue therefore stops at DEPTH-1 slots. One idle cycle then admits the last slot.
- R4: A writeback to a slot still waiting for its result stores value, PC and mispredict flag, and marks the slot complete (state code 3). A writeback to a free or already-complete slot is ignored.
- R5: When the oldest slot is complete at a clock edge and no redirect is pending, it retires at that edge. For the next cycle only, `cm_valid` is 1 and the bundle shows its tag, destination, value and PC. The oldest-slot pointer advances by one, modulo DEPTH.
- R6: Retirement is strictly in order: a complete slot never retires while an older slot is still waiting.
- R7: Register zero is special in two ways. A retiring slot whose destination is 0 gives `cm_has_dest` = 0. A query for register 0 never hits.
- R8: A retiring slot whose mispredict flag is set raises `cm_redirect` together with `cm_valid`. In that cycle `iss_ready` is 0 and nothing retires. At the next edge the queue becomes empty and the tail returns to slot 0.
- R9: Each query port registers its answer at the next edge. Among the occupied slots with a matching destination, the youngest decides the answer. If that slot is complete, `q_hit` is 1 and `q_val` is its value. If it is still waiting, `q_hit` is 0 and `q_val` is 0.
- R10: A query against an empty queue returns `q_hit` = 0. Slots already retired are never matched.
- R11: The query ports are independent; each answers for its own register number in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_dest_en | input | 1 | Issued instruction writes a register |
| iss_dest | input | AREG_W | Destination register number |
| iss_ready | output | 1 | Issue would be accepted this cycle |
| iss_tag | output | PTR_W | Slot the next issue occupies |
| wb_valid | input | 1 | Result writeback |
| wb_tag | input | PTR_W | Slot being written back |
| wb_value | input | XLEN | Result value |
| wb_pc | input | XLEN | Resulting PC |
| wb_mispred | input | 1 | Next-PC prediction was wrong |
| cm_valid | output | 1 | A slot retired at the last edge |
| cm_has_dest | output | 1 | Retired slot writes a nonzero register |
| cm_dest | output | AREG_W | Retired destination register |
| cm_value | output | XLEN | Retired value |
| cm_tag | output | PTR_W | Retired slot number |
| cm_pc | output | XLEN | Retired resulting PC |
| cm_redirect | output | 1 | Retired slot was mispredicted; flush follows |
| q_src | input | NPORT x AREG_W | Query register numbers |
| q_hit | output | NPORT | Youngest writer has its value |
| q_val | output | NPORT x XLEN | Value for a hit, else 0 |

## Verification
`iss_ready` and `iss_tag` are combinational and are read one time step after inputs are driven, before the edge that would accept the issue. Query answers appear one edge after the query register number is presented. The checks therefore present a query only after the writeback edges have passed, then sample one edge later. A writeback reaches the commit bundle two edges later: one edge marks the slot complete and the next edge retires it. Every commit check is placed after that second edge, and the retire sequence after a long wait is checked edge by edge. A redirect is checked in the cycle it is shown, and the empty queue and reset tail are checked after the single following edge.

// File: rtl/rob_pkg.sv
package rob_pkg;

  parameter int unsigned XLEN   = 32;
  parameter int unsigned AREG_W = 5;

  // Slot life cycle; the complete code is 3 by convention of the core.
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd3
  } rob_state_e;

  typedef struct packed {
    rob_state_e          state;
    logic                dest_en;
    logic [AREG_W-1:0]   dest;
    logic [XLEN-1:0]     value;
    logic [XLEN-1:0]     next_pc;
    logic                mispred;
  } rob_entry_t;

endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic             retire_fire,
  input  logic             flush,
  output logic             iss_ready,
  output logic             iss_accept,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic [CNT_W-1:0] count_q
);

  logic [PTR_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] count_d, free_w;
  logic             issued_last_q, issued_last_d;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // Free space is reduced by one more slot if an issue landed at the last edge.
  always_comb begin
    free_w     = CNT_W'(DEPTH) - count_q;
    iss_ready  = !flush && (free_w > CNT_W'(issued_last_q));
    iss_accept = iss_valid && iss_ready;
  end

  always_comb begin
    head_d        = head_q;
    tail_d        = tail_q;
    count_d       = count_q;
    issued_last_d = iss_accept;
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      if (iss_accept)  tail_d = bump(tail_q);
      if (retire_fire) head_d = bump(head_q);
      unique case ({iss_accept, retire_fire})
        2'b10:   count_d = count_q + CNT_W'(1);
        2'b01:   count_d = count_q - CNT_W'(1);
        default: count_d = count_q;
      endcase
    end
    ptr_en = flush || iss_accept || retire_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (ptr_en) begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued_last_q <= 1'b0;
    else        issued_last_q <= issued_last_d;
  end

endmodule

// File: rtl/rob_storage.sv
module rob_storage
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_we,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  logic              alloc_dest_en,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic              wb_valid,
  input  logic [PTR_W-1:0]  wb_idx,
  input  logic [XLEN-1:0]   wb_value,
  input  logic [XLEN-1:0]   wb_pc,
  input  logic              wb_mispred,
  input  logic              retire_fire,
  input  logic [PTR_W-1:0]  head_idx,
  output rob_entry_t        ent_q [DEPTH]
);

  rob_entry_t       ent_d [DEPTH];
  logic [DEPTH-1:0] ent_en;

  always_comb begin
    for (int g = 0; g < DEPTH; g++) begin
      ent_d[g]  = ent_q[g];
      ent_en[g] = 1'b0;
      if (flush) begin
        ent_d[g].state = ST_FREE;
        ent_en[g]      = 1'b1;
      end else begin
        if (retire_fire && head_idx == PTR_W'(g)) begin
          ent_d[g].state = ST_FREE;
          ent_en[g]      = 1'b1;
        end
        // Only a slot still waiting accepts a result.
        if (wb_valid && wb_idx == PTR_W'(g) && ent_q[g].state == ST_WAIT) begin
          ent_d[g].state   = ST_DONE;
          ent_d[g].value   = wb_value;
          ent_d[g].next_pc = wb_pc;
          ent_d[g].mispred = wb_mispred;
          ent_en[g]        = 1'b1;
        end
        if (alloc_we && alloc_idx == PTR_W'(g)) begin
          ent_d[g].state   = ST_WAIT;
          ent_d[g].dest_en = alloc_dest_en;
          ent_d[g].dest    = alloc_dest;
          ent_d[g].value   = '0;
          ent_d[g].next_pc = '0;
          ent_d[g].mispred = 1'b0;
          ent_en[g]        = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < DEPTH; g++) ent_q[g] <= '0;
    end else begin
      for (int g = 0; g < DEPTH; g++) begin
        if (ent_en[g]) ent_q[g] <= ent_d[g];
      end
    end
  end

endmodule

// File: rtl/rob_operand_search.sv
module rob_operand_search
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rob_entry_t        ent_q [DEPTH],
  input  logic [PTR_W-1:0]  head_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic [AREG_W-1:0] src,
  output logic              hit_q,
  output logic [XLEN-1:0]   val_q
);

  logic            hit_d;
  logic [XLEN-1:0] val_d;

  // Oldest to youngest: the last matching slot decides the answer.
  always_comb begin
    hit_d = 1'b0;
    val_d = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int unsigned slot;
      slot = (int'(head_q) + k) % DEPTH;
      if (k < int'(count_q) && src != '0 &&
          ent_q[slot[PTR_W-1:0]].dest_en && ent_q[slot[PTR_W-1:0]].dest == src) begin
        if (ent_q[slot[PTR_W-1:0]].state == ST_DONE) begin
          hit_d = 1'b1;
          val_d = ent_q[slot[PTR_W-1:0]].value;
        end else begin
          hit_d = 1'b0;
          val_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      val_q <= '0;
    end else begin
      hit_q <= hit_d;
      val_q <= val_d;
    end
  end

endmodule

// File: rtl/rob_commit_stage.sv
module rob_commit_stage
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rob_entry_t        head_ent,
  input  logic [PTR_W-1:0]  head_idx,
  input  logic              occupied,
  input  logic              flush,
  output logic              retire_fire,
  output logic              cm_valid,
  output logic              cm_has_dest,
  output logic [AREG_W-1:0] cm_dest,
  output logic [XLEN-1:0]   cm_value,
  output logic [PTR_W-1:0]  cm_tag,
  output logic [XLEN-1:0]   cm_pc,
  output logic              cm_redirect
);

  assign retire_fire = !flush && occupied && head_ent.state == ST_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_valid    <= 1'b0;
      cm_redirect <= 1'b0;
    end else begin
      cm_valid    <= retire_fire;
      cm_redirect <= retire_fire && head_ent.mispred;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_has_dest <= 1'b0;
      cm_dest     <= '0;
      cm_value    <= '0;
      cm_tag      <= '0;
      cm_pc       <= '0;
    end else if (retire_fire) begin
      cm_has_dest <= head_ent.dest_en && head_ent.dest != '0;
      cm_dest     <= head_ent.dest;
      cm_value    <= head_ent.value;
      cm_tag      <= head_idx;
      cm_pc       <= head_ent.next_pc;
    end
  end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NPORT = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         iss_valid,
  input  logic                         iss_dest_en,
  input  logic [AREG_W-1:0]            iss_dest,
  output logic                         iss_ready,
  output logic [PTR_W-1:0]             iss_tag,
  input  logic                         wb_valid,
  input  logic [PTR_W-1:0]             wb_tag,
  input  logic [XLEN-1:0]              wb_value,
  input  logic [XLEN-1:0]              wb_pc,
  input  logic                         wb_mispred,
  output logic                         cm_valid,
  output logic                         cm_has_dest,
  output logic [AREG_W-1:0]            cm_dest,
  output logic [XLEN-1:0]              cm_value,
  output logic [PTR_W-1:0]             cm_tag,
  output logic [XLEN-1:0]              cm_pc,
  output logic                         cm_redirect,
  input  logic [NPORT-1:0][AREG_W-1:0] q_src,
  output logic [NPORT-1:0]             q_hit,
  output logic [NPORT-1:0][XLEN-1:0]   q_val
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             iss_accept, retire_fire;
  rob_entry_t       ent_q [DEPTH];

  assign iss_tag = tail_q;

  rob_alloc_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .retire_fire (retire_fire),
    .flush       (cm_redirect),
    .iss_ready   (iss_ready),
    .iss_accept  (iss_accept),
    .head_q      (head_q),
    .tail_q      (tail_q),
    .count_q     (count_q)
  );

  rob_storage #(.DEPTH(DEPTH)) store_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (cm_redirect),
    .alloc_we      (iss_accept),
    .alloc_idx     (tail_q),
    .alloc_dest_en (iss_dest_en),
    .alloc_dest    (iss_dest),
    .wb_valid      (wb_valid),
    .wb_idx        (wb_tag),
    .wb_value      (wb_value),
    .wb_pc         (wb_pc),
    .wb_mispred    (wb_mispred),
    .retire_fire   (retire_fire),
    .head_idx      (head_q),
    .ent_q         (ent_q)
  );

  rob_commit_stage #(.DEPTH(DEPTH)) commit_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_ent    (ent_q[head_q]),
    .head_idx    (head_q),
    .occupied    (count_q != '0),
    .flush       (cm_redirect),
    .retire_fire (retire_fire),
    .cm_valid    (cm_valid),
    .cm_has_dest (cm_has_dest),
    .cm_dest     (cm_dest),
    .cm_value    (cm_value),
    .cm_tag      (cm_tag),
    .cm_pc       (cm_pc),
    .cm_redirect (cm_redirect)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_query
    rob_operand_search #(.DEPTH(DEPTH)) search_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ent_q   (ent_q),
      .head_q  (head_q),
      .count_q (count_q),
      .src     (q_src[p]),
      .hit_q   (q_hit[p]),
      .val_q   (q_val[p])
    );
  end

endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NPORT = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [CNT_W-1:0]  count_q,
  input logic [PTR_W-1:0]  head_q,
  input logic              cm_valid,
  input logic              cm_redirect,
  input logic              cm_has_dest,
  input logic [AREG_W-1:0] cm_dest,
  input logic [PTR_W-1:0]  cm_tag,
  input logic [NPORT-1:0]  q_hit
);

  logic [PTR_W-1:0] tag_next;
  assign tag_next = (cm_tag == PTR_W'(DEPTH - 1)) ? '0 : cm_tag + PTR_W'(1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> (count_q < CNT_W'(DEPTH)));

  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |=> !cm_valid);

  a_r5_head_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_redirect) |-> (head_q == tag_next));

  a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    cm_has_dest |-> (cm_dest != '0));

  a_r8_redirect_commits: assert property (@(posedge clk) disable iff (!rst_n)
    cm_redirect |-> (cm_valid && !iss_ready));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cm_redirect |=> (count_q == '0 && head_q == '0 && !cm_valid));

  a_r10_empty_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |=> (q_hit == '0));

endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .NPORT(NPORT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .count_q     (count_q),
  .head_q      (head_q),
  .cm_valid    (cm_valid),
  .cm_redirect (cm_redirect),
  .cm_has_dest (cm_has_dest),
  .cm_dest     (cm_dest),
  .cm_tag      (cm_tag),
  .q_hit       (q_hit)
);

// File: tb/reorder_buf_tb.sv
`timescale 1ns/1ps
module reorder_buf_tb_top;

  localparam int DEPTH = 8;
  localparam int NPORT = 2;
  localparam int PTR_W = $clog2(DEPTH);

  logic                  clk, rst_n;
  logic                  iss_valid, iss_dest_en, iss_ready;
  logic [4:0]            iss_dest;
  logic [PTR_W-1:0]      iss_tag, wb_tag, cm_tag;
  logic                  wb_valid, wb_mispred;
  logic [31:0]           wb_value, wb_pc, cm_value, cm_pc;
  logic                  cm_valid, cm_has_dest, cm_redirect;
  logic [4:0]            cm_dest;
  logic [NPORT-1:0][4:0]  q_src;
  logic [NPORT-1:0]       q_hit;
  logic [NPORT-1:0][31:0] q_val;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  reorder_buf #(.DEPTH(DEPTH), .NPORT(NPORT)) dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wb(input int tag, input logic [31:0] val, input logic [31:0] pc, input logic mis);
    wb_valid = 1'b1; wb_tag = PTR_W'(tag); wb_value = val; wb_pc = pc; wb_mispred = mis;
    step();
    wb_valid = 1'b0; wb_mispred = 1'b0;
  endtask

  task automatic chk_commit(input string req, input int tag, input int dest, input logic hasd,
                            input logic [31:0] val, input logic [31:0] pc, input logic redir);
    check({req, " cm_valid"}, cm_valid, 1);
    check({req, " cm_tag"}, cm_tag, tag);
    check({req, " cm_dest"}, cm_dest, dest);
    check({req, " cm_has_dest"}, cm_has_dest, hasd);
    check({req, " cm_value"}, cm_value, val);
    check({req, " cm_pc"}, cm_pc, pc);
    check({req, " cm_redirect"}, cm_redirect, redir);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; iss_valid = 0; iss_dest_en = 0; iss_dest = '0;
    wb_valid = 0; wb_tag = '0; wb_value = '0; wb_pc = '0; wb_mispred = 0;
    q_src = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 iss_ready", iss_ready, 1);
    check("R1 iss_tag", iss_tag, 0);
    check("R1 cm_valid", cm_valid, 0);
    check("R1 cm_redirect", cm_redirect, 0);
    check("R1 q_hit", q_hit, 0);

    // R2/R3: back-to-back issue stops at DEPTH-1; slot k writes register (k%3)+1
    iss_valid = 1'b1; iss_dest_en = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      iss_dest = 5'((k % 3) + 1);
      #1;
      if (k < DEPTH - 1) begin
        check("R3 ready while filling", iss_ready, 1);
        check("R2 sequential tag", iss_tag, k);
        step();
      end else begin
        check("R3 refused after back-to-back", iss_ready, 0);
      end
    end
    iss_valid = 1'b0;
    step();
    iss_valid = 1'b1; iss_dest = 5'(((DEPTH - 1) % 3) + 1);
    #1;
    check("R3 last slot after idle", iss_ready, 1);
    check("R2 last tag", iss_tag, DEPTH - 1);
    step();
    #1;
    check("R3 full", iss_ready, 0);
    iss_valid = 1'b0;

    // R9 all waiting
    q_src[0] = 5'd1; step();
    check("R9 waiting writer miss", q_hit[0], 0);

    // R4/R6/R9/R11
    wb(6, 32'h106, 32'h1018, 0);
    wb(3, 32'h103, 32'h100c, 0);
    q_src[0] = 5'd1; q_src[1] = 5'd2; step();
    check("R9 youngest done writer hit", q_hit[0], 1);
    check("R9 youngest value", q_val[0], 32'h106);
    check("R11 other port miss", q_hit[1], 0);
    check("R6 no commit past waiting head", cm_valid, 0);
    wb(1, 32'h101, 32'h1004, 0);
    wb(4, 32'h104, 32'h1010, 0);
    wb(2, 32'h102, 32'h1008, 0);
    q_src[0] = 5'd3; step();
    check("R9 younger waiting cancels hit", q_hit[1], 0);
    check("R9 cancelled value zero", q_val[1], 0);
    check("R9 rs3 youngest waiting", q_hit[0], 0);
    wb(5, 32'h105, 32'h1014, 0);
    step();
    check("R11 port0 hit", q_hit[0], 1);
    check("R11 port0 value", q_val[0], 32'h105);
    check("R11 port1 still miss", q_hit[1], 0);

    // R5 in-order retirement once the head completes
    wb(0, 32'h100, 32'h1000, 0);
    for (int k = 0; k < DEPTH - 1; k++) begin
      step();
      chk_commit("R5", k, (k % 3) + 1, 1, 32'h100 + k, 32'h1000 + 4 * k, 0);
    end
    q_src[0] = 5'd1;
    step();
    check("R6 waiting slot blocks retire", cm_valid, 0);
    check("R10 retired slots not matched", q_hit[0], 0);

    // R7 register zero; R4 second writeback ignored
    iss_valid = 1'b1; iss_dest = 5'd0; #1;
    check("R2 wrapped tag", iss_tag, 0);
    step(); iss_valid = 1'b0;
    wb(0, 32'h55, 32'h3000, 0);
    wb(0, 32'h66, 32'h3004, 0);
    q_src[0] = 5'd0; step();
    check("R7 query x0 miss", q_hit[0], 0);
    wb(7, 32'h107, 32'h101c, 0);
    step();
    chk_commit("R5 tail slot", 7, 2, 1, 32'h107, 32'h101c, 0);
    step();
    chk_commit("R7/R4 x0 slot", 0, 0, 0, 32'h55, 32'h3000, 0);
    q_src[0] = 5'd2; step();
    check("R10 empty miss", q_hit[0], 0);

    // R4 writeback to a free slot is ignored
    wb(1, 32'h77, 32'h4000, 0);
    iss_valid = 1'b1; iss_dest = 5'd5; #1;
    check("R2 tag after drain", iss_tag, 1);
    step(); iss_valid = 1'b0;
    step(); step();
    check("R4 free-slot writeback ignored", cm_valid, 0);

    // R8 redirect and flush
    iss_valid = 1'b1; iss_dest = 5'd6; #1;
    check("R2 tag 2", iss_tag, 2);
    step(); iss_valid = 1'b0;
    wb(1, 32'h200, 32'h2000, 1);
    wb(2, 32'h201, 32'h2004, 0);
    chk_commit("R8", 1, 5, 1, 32'h200, 32'h2000, 1);
    check("R8 issue blocked in redirect", iss_ready, 0);
    step();
    check("R8 nothing retires after redirect", cm_valid, 0);
    check("R8 ready after flush", iss_ready, 1);
    check("R8 tail reset", iss_tag, 0);
    q_src[0] = 5'd6; step();
    check("R8 flushed slot not matched", q_hit[0], 0);

    // R2/R5 wrap sweep, one instruction in flight
    for (int r = 0; r < 20; r++) begin
      iss_valid = 1'b1; iss_dest = 5'((r % 7) + 1); #1;
      check("R2 sweep tag", iss_tag, r % DEPTH);
      step(); iss_valid = 1'b0;
      wb(r % DEPTH, 32'h500 + 3 * r, 32'h6000 + 4 * r, 0);
      step();
      chk_commit("R5 sweep", r % DEPTH, (r % 7) + 1, 1, 32'h500 + 3 * r, 32'h6000 + 4 * r, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule